// File: doc/BRIEF.md
# Four-Wide In-Order Issue Selector

This block decides, each cycle, which instructions of a four-entry packet may leave for execution on a statically scheduled four-wide machine. A packet of decoded instructions arrives over a valid/ready stream and is held inside the block. Each cycle the block walks the retained slots from oldest to youngest. It issues the longest run of them that raises no hazard of three kinds: a hazard against older slots issuing in the same cycle, a hazard against work still in flight, or a shortage of functional units. The in-flight state arrives as a per-register busy vector driven by the execution side.

Slots that cannot issue stay in the block and are examined again on the next cycle. A new packet is taken only when every slot of the held one has left. The input handshake follows these rules. `pkt_ready` is high whenever no packet is held, or when the last retained slots all issue in the current cycle, so packets can follow back to back. A transfer happens on a rising edge where `pkt_valid` and `pkt_ready` are both high. While `pkt_ready` is low, the packet inputs are not sampled.

The outputs report the slots that issue this cycle, how many they are, and whether part of the packet stays for the next cycle.

Top module: `quad_issue_sel`

## Requirements
- R1: After reset and while idle, no packet is held: `issue_mask` is 0, `issue_cnt` is 0, `hold` is 0 and `pkt_ready` is 1.
- R2: A packet is captured on an edge with `pkt_valid` and `pkt_ready` high. `pkt_ready` is low while slots remain beyond the current cycle, and packet inputs offered then are ignored.
- R3: Issue is an in-order prefix of the retained slots: once a retained slot is blocked, no younger slot issues that cycle, and zero slots may issue.
- R4: A slot whose used source register (flags `pkt_rd_a`/`pkt_rd_b`) equals the destination of an older slot issuing in the same cycle with `pkt_wr_dst` set is blocked.
- R5: A slot that writes a register also written by an older slot issuing in the same cycle is blocked; a slot with `pkt_wr_dst` clear is never blocked for this reason.
- R6: Per cycle at most 2 issued slots have class ALU (code 0), 1 MUL (code 1), 1 MEM (code 2) and 1 branch (code 3); class is 2 bits per slot, slot 0 in the lowest bits.
- R7: A slot is blocked while `reg_busy` is set for a source it uses or for the destination it writes.
- R8: A source whose use flag is clear is not checked against `reg_busy` or older slots.
- R9: Blocked slots are retained and rechecked next cycle; slots already issued never issue again and no longer count as older slots.
- R10: `issue_cnt` equals the number of bits set in `issue_mask`, and `hold` is 1 exactly when retained slots remain after this cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet offered |
| pkt_ready | output | 1 | Packet can be taken |
| pkt_cls | input | 8 | Unit class per slot, 2 bits each |
| pkt_dst | input | 20 | Destination register per slot, 5 bits each |
| pkt_src_a | input | 20 | First source register per slot |
| pkt_src_b | input | 20 | Second source register per slot |
| pkt_wr_dst | input | 4 | Slot writes its destination |
| pkt_rd_a | input | 4 | Slot reads its first source |
| pkt_rd_b | input | 4 | Slot reads its second source |
| reg_busy | input | 32 | Register has a result pending in execution |
| issue_mask | output | 4 | Slots issuing this cycle |
| issue_cnt | output | 3 | Number of slots issuing |
| hold | output | 1 | Part of the packet stays for the next cycle |

## Verification
The assertions take `reg_busy` as a full account of work in flight. Once a slot has issued, its conflicts with younger slots of the same packet are no longer tracked internally, so the execution side must mark its destination busy if that matters. The block puts no stability demand on the packet inputs while `pkt_ready` is low, and the stimulus deliberately changes them in that window. All class codes are legal. The stimulus sets the busy vector explicitly for each case and clears it when the packet is meant to drain, so every expected mask follows from the requirements alone.

// File: rtl/iss_pkg.sv
package iss_pkg;
  localparam int REG_IDX_W = 5;
  localparam int CLS_W     = 2;
  localparam int NUM_CLS   = 1 << CLS_W;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU = 2'd0,
    CLS_MUL = 2'd1,
    CLS_MEM = 2'd2,
    CLS_BR  = 2'd3
  } iss_cls_e;

  typedef struct packed {
    iss_cls_e               cls;
    logic [REG_IDX_W-1:0]   dst;
    logic [REG_IDX_W-1:0]   src_a;
    logic [REG_IDX_W-1:0]   src_b;
    logic                   wr_dst;
    logic                   rd_a;
    logic                   rd_b;
  } iss_slot_t;
endpackage

// File: rtl/iss_pkt_hold.sv
module iss_pkt_hold
  import iss_pkg::*;
#(
  parameter int NSLOT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  iss_slot_t [NSLOT-1:0] in_slots,
  input  logic [NSLOT-1:0]      issue_mask,
  output iss_slot_t [NSLOT-1:0] held_slots,
  output logic [NSLOT-1:0]      pending,
  output logic [NSLOT-1:0]      left_after
);
  logic accept;

  assign left_after = pending & ~issue_mask;
  assign in_ready   = (left_after == '0);
  assign accept     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending    <= '0;
      held_slots <= '0;
    end else if (accept) begin
      pending    <= '1;
      held_slots <= in_slots;
    end else begin
      pending    <= left_after;
    end
  end

  // R2
  load_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pending == '1));

  // R9
  retain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (pending == $past(left_after)) && $stable(held_slots));
endmodule

// File: rtl/iss_sb_check.sv
module iss_sb_check
  import iss_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int NREG  = 32
) (
  input  iss_slot_t [NSLOT-1:0] slots,
  input  logic [NREG-1:0]       busy,
  output logic [NSLOT-1:0]      blocked
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic hit_a, hit_b, hit_d;
    assign hit_a = slots[s].rd_a   && busy[slots[s].src_a];
    assign hit_b = slots[s].rd_b   && busy[slots[s].src_b];
    assign hit_d = slots[s].wr_dst && busy[slots[s].dst];
    assign blocked[s] = hit_a || hit_b || hit_d;
  end
endmodule

// File: rtl/iss_prefix_sel.sv
module iss_prefix_sel
  import iss_pkg::*;
#(
  parameter int NSLOT   = 4,
  parameter int LIM_ALU = 2,
  parameter int LIM_MUL = 1,
  parameter int LIM_MEM = 1,
  parameter int LIM_BR  = 1,
  localparam int CNT_W  = $clog2(NSLOT + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  iss_slot_t [NSLOT-1:0] slots,
  input  logic [NSLOT-1:0]      pending,
  input  logic [NSLOT-1:0]      sb_block,
  output logic [NSLOT-1:0]      issue_mask,
  output logic [CNT_W-1:0]      issue_cnt
);
  function automatic int unit_lim(iss_cls_e c);
    case (c)
      CLS_ALU: return LIM_ALU;
      CLS_MUL: return LIM_MUL;
      CLS_MEM: return LIM_MEM;
      default: return LIM_BR;
    endcase
  endfunction

  always_comb begin
    logic stop;
    logic dep;
    logic full;
    int   used [NUM_CLS];
    int   n;
    stop = 1'b0;
    n    = 0;
    for (int c = 0; c < NUM_CLS; c++) used[c] = 0;
    issue_mask = '0;
    for (int i = 0; i < NSLOT; i++) begin
      dep = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (issue_mask[j] && slots[j].wr_dst) begin
          if (slots[i].rd_a && (slots[i].src_a == slots[j].dst)) dep = 1'b1;
          if (slots[i].rd_b && (slots[i].src_b == slots[j].dst)) dep = 1'b1;
          if (slots[i].wr_dst && (slots[i].dst == slots[j].dst)) dep = 1'b1;
        end
      end
      full = (used[int'(slots[i].cls)] >= unit_lim(slots[i].cls));
      if (pending[i] && !stop) begin
        if (!dep && !full && !sb_block[i]) begin
          issue_mask[i] = 1'b1;
          used[int'(slots[i].cls)] = used[int'(slots[i].cls)] + 1;
          n = n + 1;
        end else begin
          stop = 1'b1;
        end
      end
    end
    issue_cnt = CNT_W'(n);
  end

  // R3
  for (genvar k = 0; k < NSLOT - 1; k++) begin : g_ord
    prefix_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_mask[k+1] && pending[k]) |-> issue_mask[k]);
  end

  // R9
  pending_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_mask & ~pending) == '0);

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_mask & sb_block) == '0);
endmodule

// File: rtl/quad_issue_sel.sv
module quad_issue_sel
  import iss_pkg::*;
#(
  parameter int NSLOT   = 4,
  parameter int LIM_ALU = 2,
  parameter int LIM_MUL = 1,
  parameter int LIM_MEM = 1,
  parameter int LIM_BR  = 1,
  localparam int RW     = REG_IDX_W,
  localparam int NREG   = 1 << RW,
  localparam int CNT_W  = $clog2(NSLOT + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pkt_valid,
  output logic                  pkt_ready,
  input  logic [NSLOT*CLS_W-1:0] pkt_cls,
  input  logic [NSLOT*RW-1:0]   pkt_dst,
  input  logic [NSLOT*RW-1:0]   pkt_src_a,
  input  logic [NSLOT*RW-1:0]   pkt_src_b,
  input  logic [NSLOT-1:0]      pkt_wr_dst,
  input  logic [NSLOT-1:0]      pkt_rd_a,
  input  logic [NSLOT-1:0]      pkt_rd_b,
  input  logic [NREG-1:0]       reg_busy,
  output logic [NSLOT-1:0]      issue_mask,
  output logic [CNT_W-1:0]      issue_cnt,
  output logic                  hold
);
  iss_slot_t [NSLOT-1:0] in_slots;
  iss_slot_t [NSLOT-1:0] held_slots;
  logic [NSLOT-1:0]      pending;
  logic [NSLOT-1:0]      left_after;
  logic [NSLOT-1:0]      sb_block;

  for (genvar s = 0; s < NSLOT; s++) begin : g_pack
    assign in_slots[s].cls    = iss_cls_e'(pkt_cls[s*CLS_W +: CLS_W]);
    assign in_slots[s].dst    = pkt_dst[s*RW +: RW];
    assign in_slots[s].src_a  = pkt_src_a[s*RW +: RW];
    assign in_slots[s].src_b  = pkt_src_b[s*RW +: RW];
    assign in_slots[s].wr_dst = pkt_wr_dst[s];
    assign in_slots[s].rd_a   = pkt_rd_a[s];
    assign in_slots[s].rd_b   = pkt_rd_b[s];
  end

  iss_pkt_hold #(.NSLOT(NSLOT)) hold_u (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pkt_valid),
    .in_ready  (pkt_ready),
    .in_slots  (in_slots),
    .issue_mask(issue_mask),
    .held_slots(held_slots),
    .pending   (pending),
    .left_after(left_after)
  );

  iss_sb_check #(.NSLOT(NSLOT), .NREG(NREG)) sb_u (
    .slots  (held_slots),
    .busy   (reg_busy),
    .blocked(sb_block)
  );

  iss_prefix_sel #(
    .NSLOT(NSLOT), .LIM_ALU(LIM_ALU), .LIM_MUL(LIM_MUL),
    .LIM_MEM(LIM_MEM), .LIM_BR(LIM_BR)
  ) sel_u (
    .clk       (clk),
    .rst_n     (rst_n),
    .slots     (held_slots),
    .pending   (pending),
    .sb_block  (sb_block),
    .issue_mask(issue_mask),
    .issue_cnt (issue_cnt)
  );

  assign hold = (left_after != '0);

  // Per-class membership of held slots, used by the unit-limit checks.
  localparam int UNIT_LIM [NUM_CLS] = '{LIM_ALU, LIM_MUL, LIM_MEM, LIM_BR};
  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    logic [NSLOT-1:0] in_cls;
    for (genvar s = 0; s < NSLOT; s++) begin : g_m
      assign in_cls[s] = (held_slots[s].cls == iss_cls_e'(c));
    end
    // R6
    unit_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(issue_mask & in_cls) <= UNIT_LIM[c]);
  end

  // R10
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(issue_cnt) == $countones(issue_mask));

  // R2
  hold_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !pkt_ready);
endmodule

// File: tb/quad_issue_sel_tb_top.sv
module quad_issue_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pkt_valid;
  logic        pkt_ready;
  logic [7:0]  pkt_cls;
  logic [19:0] pkt_dst, pkt_src_a, pkt_src_b;
  logic [3:0]  pkt_wr_dst, pkt_rd_a, pkt_rd_b;
  logic [31:0] reg_busy;
  logic [3:0]  issue_mask;
  logic [2:0]  issue_cnt;
  logic        hold;

  always #2.5 clk = ~clk;

  quad_issue_sel dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_cls(pkt_cls), .pkt_dst(pkt_dst), .pkt_src_a(pkt_src_a),
    .pkt_src_b(pkt_src_b), .pkt_wr_dst(pkt_wr_dst), .pkt_rd_a(pkt_rd_a),
    .pkt_rd_b(pkt_rd_b), .reg_busy(reg_busy), .issue_mask(issue_mask),
    .issue_cnt(issue_cnt), .hold(hold)
  );

  typedef struct {
    logic [3:0] m;
    int         c;
    bit         h;
    bit         r;
    string      tag;
  } exp_t;

  exp_t exp_q [$];
  int   errors = 0;
  int   checks = 0;
  bit   done   = 1'b0;

  // Monitor: compares away from the active edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (issue_mask !== e.m || int'(issue_cnt) != e.c || hold !== e.h || pkt_ready !== e.r) begin
        errors++;
        $display("FAIL %s: mask=%b cnt=%0d hold=%b ready=%b expected mask=%b cnt=%0d hold=%b ready=%b",
                 e.tag, issue_mask, issue_cnt, hold, pkt_ready, e.m, e.c, e.h, e.r);
      end
    end
  end

  task automatic set_slot(int s, int cls, int d, int a, int b, bit w, bit ra, bit rb);
    pkt_cls[s*2 +: 2]   = 2'(cls);
    pkt_dst[s*5 +: 5]   = 5'(d);
    pkt_src_a[s*5 +: 5] = 5'(a);
    pkt_src_b[s*5 +: 5] = 5'(b);
    pkt_wr_dst[s]       = w;
    pkt_rd_a[s]         = ra;
    pkt_rd_b[s]         = rb;
  endtask

  // Driver: pushes the expectation for the current cycle, then advances.
  task automatic step(logic [3:0] m, int c, bit h, bit r, string tag);
    exp_t e;
    e.m = m; e.c = c; e.h = h; e.r = r; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pkt_valid = 1'b0; reg_busy = '0;
    pkt_cls = '0; pkt_dst = '0; pkt_src_a = '0; pkt_src_b = '0;
    pkt_wr_dst = '0; pkt_rd_a = '0; pkt_rd_b = '0;
    @(posedge clk); #1;
    step(4'b0000, 0, 0, 1, "R1 in reset");
    rst_n = 1'b1;
    step(4'b0000, 0, 0, 1, "R1 idle after reset");

    // Independent packet, one of each class.
    set_slot(0, 0, 1, 10, 11, 1, 1, 1);
    set_slot(1, 1, 2, 12, 13, 1, 1, 1);
    set_slot(2, 2, 3, 14, 0, 1, 1, 0);
    set_slot(3, 3, 0, 15, 0, 0, 1, 0);
    pkt_valid = 1'b1;
    step(4'b0000, 0, 0, 1, "R2 load A");
    pkt_valid = 1'b0;
    step(4'b1111, 4, 0, 1, "R10 all four issue");

    // RAW inside the packet.
    set_slot(0, 0, 5, 1, 0, 1, 1, 0);
    set_slot(1, 0, 6, 5, 0, 1, 1, 0);
    set_slot(2, 2, 3, 4, 0, 1, 1, 0);
    set_slot(3, 3, 0, 7, 0, 0, 1, 0);
    pkt_valid = 1'b1;
    step(4'b0000, 0, 0, 1, "R2 load B");
    pkt_valid = 1'b0;
    step(4'b0001, 1, 1, 0, "R4 RAW blocks slot1, R3 younger stop");

    // Remaining slots drain while the next packet is taken.
    set_slot(0, 2, 7, 1, 0, 1, 1, 0);
    set_slot(1, 2, 8, 2, 0, 1, 1, 0);
    set_slot(2, 0, 10, 0, 0, 1, 0, 0);
    set_slot(3, 0, 11, 0, 0, 1, 0, 0);
    pkt_valid = 1'b1;
    step(4'b1110, 3, 0, 1, "R9 recheck and R2 back-to-back load C");

    // Offer a different packet while stalled: must be ignored.
    set_slot(0, 3, 0, 0, 0, 0, 0, 0);
    set_slot(1, 3, 0, 0, 0, 0, 0, 0);
    set_slot(2, 3, 0, 0, 0, 0, 0, 0);
    set_slot(3, 3, 0, 0, 0, 0, 0, 0);
    step(4'b0001, 1, 1, 0, "R6 second MEM blocked");
    pkt_valid = 1'b0;
    step(4'b1110, 3, 0, 1, "R6 MEM then two ALU");
    step(4'b0000, 0, 0, 1, "R2 stalled offer not loaded");

    // WAW, unused source, busy source.
    reg_busy = 32'h0010_0000;
    set_slot(0, 0, 9, 20, 3, 1, 0, 1);
    set_slot(1, 0, 9, 0, 0, 1, 0, 0);
    set_slot(2, 1, 12, 20, 0, 1, 1, 0);
    set_slot(3, 3, 0, 0, 0, 0, 0, 0);
    pkt_valid = 1'b1;
    step(4'b0000, 0, 0, 1, "R2 load E");
    pkt_valid = 1'b0;
    step(4'b0001, 1, 1, 0, "R5 WAW blocks slot1, R8 unused busy source");
    step(4'b0010, 1, 1, 0, "R7 busy source blocks slot2, R9 issued slot not older");
    reg_busy = '0;
    step(4'b1100, 2, 0, 1, "R9 rest drains");

    // Busy destination and a non-writing slot sharing it.
    reg_busy = 32'h0010_0000;
    set_slot(0, 0, 20, 0, 0, 1, 0, 0);
    set_slot(1, 1, 21, 1, 0, 1, 1, 0);
    set_slot(2, 2, 22, 1, 0, 1, 1, 0);
    set_slot(3, 3, 20, 2, 0, 0, 1, 0);
    pkt_valid = 1'b1;
    step(4'b0000, 0, 0, 1, "R2 load F");
    pkt_valid = 1'b0;
    step(4'b0000, 0, 1, 0, "R7 busy destination, R3 zero issue");
    reg_busy = '0;
    step(4'b1111, 4, 0, 1, "R5 no WAW without write");
    step(4'b0000, 0, 0, 1, "R1 idle again");

    @(posedge clk); #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule